// File: doc/BRIEF.md
# Line-Table Video Fetch Address Generator

This block produces the memory read addresses that a monochrome bitmap display needs for a 720×256 pixel screen. Screen lines are not stored in order. Each displayed line is reached through a 16-bit coded pointer held in a 512-byte line table, which sits in the bottom 128 KB of memory. A location register moves the table. An origin register rotates which table entry appears on the top screen row, and this gives hardware scrolling.

For each line the block reads the two pointer bytes, low byte first, and decodes them into a bitmap base address. It then reads the 90 bitmap bytes of that line at a stride of 8 bytes. It passes each byte on, inverted or forced to zero as the display control register selects. External timing supplies three strobes: `frame_start`, `line_start` and `byte_next`. The block flags frame flyback once the last visible line has been fetched.

The sequencer has six states:
- `S_FLY`: flyback, idle. It is left on `frame_start`.
- `S_WAIT`: waiting for a line. `line_start` moves it to `S_PLO`.
- `S_PLO`: reading the pointer's low byte. `mem_ack` moves it to `S_PHI`.
- `S_PHI`: reading the pointer's high byte. `mem_ack` moves it to `S_FETCH`.
- `S_FETCH`: reading a bitmap byte. `mem_ack` moves it to `S_HOLD`.
- `S_HOLD`: presenting the byte. `byte_next` moves it to `S_FETCH`. After the 90th byte it goes to `S_WAIT`, or to `S_FLY` after the last visible row.

`frame_start` forces `S_WAIT` from any state and sets the row to 0.

Top module: `linetab_fetch`

## Requirements
- R1: After reset: `flyback`=1, `mem_req`=0, `pix_valid`=0, `blank`=1 and `invert`=0. The location and origin registers are 0.
- R2: Configuration writes set a register when `cfg_wr`=1:
  - `cfg_sel`=0 sets the table location. Bits 7:5 are the 16 KB block and bits 4:0 are the offset in 512-byte units, so the table base is {bits7:5, bits4:0, 9'b0}.
  - `cfg_sel`=1 sets the origin.
  - `cfg_sel`=2 sets display control.
  - `cfg_sel`=3 is ignored.
- R3: The table index for screen row r is (origin + r) mod 256. After `line_start`, the pointer's low byte is read at table base + 2·index and the high byte at that address + 1.
- R4: A pointer P is decoded to the 17-bit bitmap base {P[15:13], P[12:3], 1'b0, P[2:0]}.
- R5: A line's 90 bitmap bytes are read at base + 8·k for k = 0..89, modulo 2^17, one read per `byte_next`.
- R6: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, unless `frame_start` aborts the read.
- R7: `pix_valid` rises only after a bitmap read is acknowledged. It then holds until `byte_next`. `pix_byte` is the read byte, bitwise inverted when display-control bit 7 is set.
- R8: When display-control bit 6 is clear, `blank`=1 and `pix_byte`=0.
- R9: `flyback` is set after the 90th byte of row 255, or of row 199 when `mode60`=1. It stays set, with no reads and with `line_start` ignored, until `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 location, 1 origin, 2 display control |
| cfg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Start of frame; row counter goes to 0 |
| line_start | input | 1 | Begin fetching the next line |
| byte_next | input | 1 | Consume the presented byte, fetch the next |
| mode60 | input | 1 | 200 visible lines instead of 256 |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 17 | Memory read byte address |
| mem_ack | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 8 | Read data |
| pix_valid | output | 1 | `pix_byte` holds a fetched bitmap byte |
| pix_byte | output | 8 | Bitmap byte after invert and blank |
| blank | output | 1 | Display disabled |
| invert | output | 1 | Inverse video selected |
| flyback | output | 1 | Frame flyback status |

## Verification
The assertions take the memory side to be well behaved: `mem_ack` comes only while `mem_req` is high and is never held for two cycles in a row. They also take `frame_start` to be the only thing that may drop a pending read. The bench's memory responder answers one request at a time, acknowledges for a single cycle and then releases. The bench pulses `line_start` and `byte_next` only when the sequencer is waiting or presenting a byte, and changes `mode60` only between frames.

// File: rtl/linetab_pkg.sv
package linetab_pkg;
    localparam int ADDR_W    = 17;
    localparam int PTR_W     = 16;
    localparam int TBL_IDX_W = 8;

    typedef enum logic [2:0] {
        S_FLY,
        S_WAIT,
        S_PLO,
        S_PHI,
        S_FETCH,
        S_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        A_PLO,
        A_PHI,
        A_BYTE
    } addr_sel_e;

    typedef struct packed {
        logic [7:0] loc;
        logic [7:0] org;
        logic       inv;
        logic       en;
    } disp_cfg_t;
endpackage

// File: rtl/linetab_regs.sv
module linetab_regs
    import linetab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    output disp_cfg_t  cfg
);
    logic [5:0] unused_ctrl_bits;
    assign unused_ctrl_bits = cfg_wdata[5:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            unique case (cfg_sel)
                2'd0: cfg.loc <= cfg_wdata;
                2'd1: cfg.org <= cfg_wdata;
                2'd2: begin
                    cfg.inv <= cfg_wdata[7];
                    cfg.en  <= cfg_wdata[6];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/linetab_addr.sv
module linetab_addr
    import linetab_pkg::*;
#(
    parameter int STRIDE = 8,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 7
) (
    input  logic [7:0]        tbl_loc,
    input  logic [7:0]        origin,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [PTR_W-1:0]  ptr,
    input  addr_sel_e         sel,
    output logic [ADDR_W-1:0] addr
);
    logic [TBL_IDX_W-1:0] idx;
    logic [ADDR_W-1:0]    tbl_base;
    logic [ADDR_W-1:0]    entry_addr;
    logic [ADDR_W-1:0]    line_base;
    logic [ADDR_W-1:0]    byte_off;

    always_comb begin
        idx        = origin + TBL_IDX_W'(row);
        tbl_base   = {tbl_loc[7:5], tbl_loc[4:0], 9'b0};
        entry_addr = tbl_base | {8'b0, idx, 1'b0};
        line_base  = {ptr[15:13], ptr[12:3], 1'b0, ptr[2:0]};
        byte_off   = ADDR_W'(col) * ADDR_W'(STRIDE);
        unique case (sel)
            A_PLO:   addr = entry_addr;
            A_PHI:   addr = entry_addr | ADDR_W'(1);
            default: addr = line_base + byte_off;
        endcase
    end
endmodule

// File: rtl/linetab_seq.sv
module linetab_seq
    import linetab_pkg::*;
#(
    parameter int COLS     = 90,
    parameter int ROWS     = 256,
    parameter int ROWS_ALT = 200,
    parameter int ROW_W    = 8,
    parameter int COL_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic             byte_next,
    input  logic             mode60,
    input  logic             mem_ack,
    input  logic [7:0]       mem_rdata,
    output logic             mem_req,
    output addr_sel_e        sel,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic [PTR_W-1:0] ptr,
    output logic [7:0]       pix_raw,
    output logic             pix_valid,
    output logic             flyback
);
    seq_state_e state_q, state_d;
    logic last_col, last_row, line_done;

    assign last_col  = (col == COL_W'(COLS - 1));
    assign last_row  = (row == (mode60 ? ROW_W'(ROWS_ALT - 1) : ROW_W'(ROWS - 1)));
    assign line_done = (state_q == S_HOLD) && byte_next && last_col;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FLY:   if (frame_start) state_d = S_WAIT;
            S_WAIT:  if (line_start)  state_d = S_PLO;
            S_PLO:   if (mem_ack)     state_d = S_PHI;
            S_PHI:   if (mem_ack)     state_d = S_FETCH;
            S_FETCH: if (mem_ack)     state_d = S_HOLD;
            S_HOLD: begin
                if (byte_next) begin
                    if (!last_col)     state_d = S_FETCH;
                    else if (last_row) state_d = S_FLY;
                    else               state_d = S_WAIT;
                end
            end
            default: state_d = S_FLY;
        endcase
        if (frame_start) state_d = S_WAIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FLY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row     <= '0;
            col     <= '0;
            ptr     <= '0;
            pix_raw <= '0;
        end else begin
            if (frame_start)    row <= '0;
            else if (line_done) row <= row + ROW_W'(1);
            if (state_q == S_PHI && mem_ack)                    col <= '0;
            else if (state_q == S_HOLD && byte_next && !last_col) col <= col + COL_W'(1);
            if (state_q == S_PLO && mem_ack)   ptr[7:0]  <= mem_rdata;
            if (state_q == S_PHI && mem_ack)   ptr[15:8] <= mem_rdata;
            if (state_q == S_FETCH && mem_ack) pix_raw   <= mem_rdata;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        sel       = A_BYTE;
        pix_valid = 1'b0;
        flyback   = 1'b0;
        unique case (state_q)
            S_FLY:   flyback = 1'b1;
            S_WAIT:  ;
            S_PLO:   begin mem_req = 1'b1; sel = A_PLO; end
            S_PHI:   begin mem_req = 1'b1; sel = A_PHI; end
            S_FETCH: mem_req = 1'b1;
            S_HOLD:  pix_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/linetab_fetch.sv
module linetab_fetch
    import linetab_pkg::*;
#(
    parameter int COLS     = 90,
    parameter int STRIDE   = 8,
    parameter int ROWS     = 256,
    parameter int ROWS_ALT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              byte_next,
    input  logic              mode60,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              pix_valid,
    output logic [7:0]        pix_byte,
    output logic              blank,
    output logic              invert,
    output logic              flyback
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    disp_cfg_t        cfg;
    addr_sel_e        sel;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       pix_raw;

    linetab_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    linetab_seq #(
        .COLS(COLS), .ROWS(ROWS), .ROWS_ALT(ROWS_ALT), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .byte_next   (byte_next),
        .mode60      (mode60),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .sel         (sel),
        .row         (row),
        .col         (col),
        .ptr         (ptr),
        .pix_raw     (pix_raw),
        .pix_valid   (pix_valid),
        .flyback     (flyback)
    );

    linetab_addr #(.STRIDE(STRIDE), .ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
        .tbl_loc (cfg.loc),
        .origin  (cfg.org),
        .row     (row),
        .col     (col),
        .ptr     (ptr),
        .sel     (sel),
        .addr    (mem_addr)
    );

    assign blank    = !cfg.en;
    assign invert   = cfg.inv;
    assign pix_byte = !cfg.en ? 8'h00 : (cfg.inv ? ~pix_raw : pix_raw);
endmodule

// File: rtl/linetab_chk.sv
module linetab_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_start,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [16:0] mem_addr,
    input logic        pix_valid,
    input logic [7:0]  pix_byte,
    input logic        blank,
    input logic        flyback
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !frame_start) |=> (mem_req && $stable(mem_addr))); // R6

    AST_PIX_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> $past(mem_ack)); // R7

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (pix_byte == 8'h00)); // R8

    AST_FLY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        flyback |-> !mem_req); // R9

    AST_FLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flyback && !frame_start) |=> flyback); // R9
endmodule

bind linetab_fetch linetab_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .pix_valid   (pix_valid),
    .pix_byte    (pix_byte),
    .blank       (blank),
    .flyback     (flyback)
);

// File: tb/test_linetab_fetch.sv
module test_linetab_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        byte_next = 1'b0;
    logic        mode60 = 1'b0;
    logic        mem_req;
    logic [16:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        pix_valid;
    logic [7:0]  pix_byte;
    logic        blank, invert, flyback;

    int checks = 0;
    int errors = 0;
    logic [7:0]  mem [int];
    logic [16:0] acked [$];
    logic [7:0]  sh_loc = 8'h00, sh_org = 8'h00, sh_ctrl = 8'h00;

    always #5 clk = ~clk;

    linetab_fetch i_linetab_fetch (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .line_start(line_start),
        .byte_next(byte_next), .mode60(mode60), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_byte(pix_byte), .blank(blank),
        .invert(invert), .flyback(flyback)
    );

    function automatic logic [7:0] rd(input logic [16:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[16:9] ^ 8'h5A;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                mem_ack   = 1'b1;
                mem_rdata = rd(mem_addr);
                acked.push_back(mem_addr);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (s == 2'd0) sh_loc = d;
        if (s == 2'd1) sh_org = d;
        if (s == 2'd2) sh_ctrl = d;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // Fetch one line for screen row r; verify when chk is set
    task automatic run_line(input int r, input bit chk);
        logic [7:0]  idx;
        logic [16:0] ent, base;
        logic [15:0] p;
        logic [7:0]  exp_pix;
        bit addr_ok, data_ok;
        acked.delete();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        data_ok = 1'b1;
        for (int k = 0; k < 90; k++) begin
            while (!pix_valid) @(negedge clk);
            if (chk) begin
                exp_pix = rd(acked[acked.size()-1]);
                if (!sh_ctrl[6]) exp_pix = 8'h00;
                else if (sh_ctrl[7]) exp_pix = ~exp_pix;
                if (pix_byte !== exp_pix) data_ok = 1'b0;
            end
            byte_next = 1'b1;
            @(negedge clk); byte_next = 1'b0;
        end
        if (chk) begin
            idx  = sh_org + 8'(r);
            ent  = {sh_loc[7:5], sh_loc[4:0], 9'b0} + {8'b0, idx, 1'b0};
            check(acked.size() == 92, "R5 read count", acked.size(), 92);
            check(acked[0] == ent && acked[1] == (ent + 17'd1), "R3 pointer fetch addr",
                  int'(acked[0]), int'(ent));
            p    = {rd(ent + 17'd1), rd(ent)};
            base = {p[15:13], p[12:3], 1'b0, p[2:0]};
            addr_ok = 1'b1;
            for (int k = 0; k < 90; k++)
                if (acked[2+k] !== 17'(base + 17'(8*k))) addr_ok = 1'b0;
            check(addr_ok, "R4 R5 bitmap addresses", int'(acked[2]), int'(base));
            check(data_ok, "R7 R8 pixel bytes", int'(pix_byte), int'(sh_ctrl));
        end
    endtask

    task automatic t_reset();
        check(flyback === 1'b1 && mem_req === 1'b0 && pix_valid === 1'b0, "R1 reset outputs",
              {flyback, mem_req, pix_valid}, 3'b100);
        check(blank === 1'b1 && invert === 1'b0, "R1 reset display", {blank, invert}, 2'b10);
    endtask

    task automatic t_basic();
        wr_reg(2'd0, 8'h99);   // block 4, offset 3200h -> 13200h
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h40);
        wr_reg(2'd3, 8'hFF);   // R2: ignored, shadow values unchanged
        mem[32'h13200] = 8'h3D; mem[32'h13201] = 8'h6A;
        mem[32'h13202] = 8'hFF; mem[32'h13203] = 8'hFF;  // R5: wrap past 1FFFFh
        check(blank === 1'b0 && invert === 1'b0, "R2 control write", {blank, invert}, 2'b00);
        pulse_frame();
        check(flyback === 1'b0, "R9 leave flyback on frame start", flyback, 0);
        run_line(0, 1'b1);
        run_line(1, 1'b1);
    endtask

    task automatic t_scroll();
        wr_reg(2'd1, 8'hFF);   // R3: row 0 -> idx 255, row 1 -> idx 0
        pulse_frame();
        run_line(0, 1'b1);
        run_line(1, 1'b1);
    endtask

    task automatic t_invert_blank();
        wr_reg(2'd2, 8'hC0);
        check(invert === 1'b1, "R7 invert flag", invert, 1);
        pulse_frame();
        run_line(0, 1'b1);
        wr_reg(2'd2, 8'h80);
        check(blank === 1'b1, "R8 blank flag", blank, 1);
        run_line(1, 1'b1);
        wr_reg(2'd2, 8'h40);
    endtask

    task automatic t_flyback();
        mode60 = 1'b0;
        pulse_frame();
        for (int r = 0; r < 200; r++) run_line(r, 1'b0);
        check(flyback === 1'b0, "R9 no flyback at 200 in 256-line mode", flyback, 0);
        for (int r = 200; r < 256; r++) run_line(r, 1'b0);
        check(flyback === 1'b1, "R9 flyback after row 255", flyback, 1);
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        repeat (4) @(negedge clk);
        check(mem_req === 1'b0 && flyback === 1'b1, "R9 line_start ignored in flyback",
              {mem_req, flyback}, 2'b01);
        mode60 = 1'b1;
        pulse_frame();
        for (int r = 0; r < 199; r++) run_line(r, 1'b0);
        check(flyback === 1'b0, "R9 no flyback before row 199", flyback, 0);
        run_line(199, 1'b0);
        check(flyback === 1'b1, "R9 flyback after row 199 in 60 Hz mode", flyback, 1);
        mode60 = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_scroll();
        t_invert_blank();
        t_flyback();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule